// File: doc/BRIEF.md
# Resistor Ladder Tap Switch Driver

This block turns a binary wiper code into the one-hot gate enables for the tap switches of a resistor ladder. It also drives the switch that joins the ladder's upper end to its terminal and the switch that ties the wiper to the lower terminal. With the default width of 7 bits the ladder has 128 taps. Code 0 drives bit 0 of `tap_en_o`, the tap nearest the lower terminal. Code 127 drives bit 127, the tap nearest the upper terminal. The position rises monotonically with the code.

A move to a new tap is make-before-break. The new tap closes at the first clock edge that samples the new code. The tap that was held before stays closed for `OVL_CYC` further edges, and only then opens. A shutdown request opens every tap and the upper-end switch, and ties the wiper to the lower end. While in shutdown the held tap is frozen. On exit the wiper returns to that tap, with no reload from elsewhere. All pins are plain control levels, so there is no stream and no handshake. The code and the shutdown request are sampled at every rising clock edge. At any practical clock rate a single-edge response stays well inside a microsecond-scale settling budget.

Top module: `tap_switch_driver`

## Requirements
- R1: After reset is released and before the first clock edge, `tap_en_o` is the one-hot of the input code, `hi_end_en_o` is 1 and `wiper_low_short_o` is 0. The first edge takes that code as the held tap, with no overlap.
- R2: Outside overlap and shutdown exactly one tap enable is 1. Its index equals the held code: bit 0 is the lower end and bit 127 the upper end. `hi_end_en_o` is 1 and `wiper_low_short_o` is 0.
- R3: When an edge samples a code that differs from the held tap, the new tap is on after that edge. The previous tap also stays on, for exactly `OVL_CYC` edges (default 2). During that time exactly two enables are 1.
- R4: When the code changes again during an overlap, the intermediate tap is replaced by the newest one. The original tap is kept, and the overlap count restarts from `OVL_CYC`.
- R5: One edge after `shut_req_i` is sampled at 1, all tap enables are 0, `hi_end_en_o` is 0 and `wiper_low_short_o` is 1. Any overlap in progress is abandoned.
- R6: Code changes during shutdown are ignored. After the edge that first samples `shut_req_i` at 0, the outputs show the one-hot of the tap held before shutdown. A differing input code starts a normal overlap at the following edge.
- R7: Outside shutdown, the enable vectors after any two consecutive edges always have at least one tap in common. The wiper is never left open.
- R8: A new code that is sampled while not in shutdown is enabled at the outputs right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wiper_code_i | input | 7 | Requested tap position |
| shut_req_i | input | 1 | Combined shutdown request, active high |
| tap_en_o | output | 128 | One enable per ladder tap, bit 0 at the lower end |
| hi_end_en_o | output | 1 | Enable for the upper-end terminal switch |
| wiper_low_short_o | output | 1 | Enable for the switch that ties the wiper to the lower terminal |

## Verification
A wrong held tap shows at `tap_en_o` at once, as a wrong index after the edge that should have loaded it. A stuck or miscounted overlap counter shows as a second enable that drops one edge early or late, or as a lost common tap between consecutive vectors. A lost shutdown flag shows within one edge on the two terminal enables. A frozen state that drifted shows in the first vector after shutdown ends.

// File: rtl/tsd_pkg.sv
package tsd_pkg;
  typedef struct packed {
    logic hi_en;
    logic lo_short;
  } term_t;

  localparam term_t TERM_RUN  = '{hi_en: 1'b1, lo_short: 1'b0};
  localparam term_t TERM_DARK = '{hi_en: 1'b0, lo_short: 1'b1};
endpackage

// File: rtl/tsd_decoder.sv
module tsd_decoder #(
  parameter int CODE_W = 7,
  localparam int TAPS = 1 << CODE_W
) (
  input  logic [CODE_W-1:0] sel,
  input  logic              en,
  output logic [TAPS-1:0]   onehot
);
  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    assign onehot[g] = en && (sel == CODE_W'(g));
  end
endmodule

// File: rtl/tsd_seq.sv
module tsd_seq #(
  parameter int CODE_W  = 7,
  parameter int OVL_CYC = 2,
  localparam int CW = $clog2(OVL_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              shut,
  output logic [CODE_W-1:0] act,
  output logic [CODE_W-1:0] old,
  output logic              ovl_on,
  output logic              primed,
  output logic              dark
);
  logic [CW-1:0] ovl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= '0;
      old    <= '0;
      ovl    <= '0;
      primed <= 1'b0;
      dark   <= 1'b0;
    end else begin
      dark <= shut;
      if (!primed) begin
        act    <= code;
        primed <= 1'b1;
        ovl    <= '0;
      end else if (shut || dark) begin
        ovl <= '0;
      end else if (code != act) begin
        if (ovl == '0) old <= act;
        act <= code;
        ovl <= CW'(OVL_CYC);
      end else if (ovl != '0) begin
        ovl <= ovl - 1'b1;
      end
    end
  end

  assign ovl_on = (ovl != '0);

  // R8: a sampled code is the held tap after that same edge
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!primed || (!shut && !dark)) |=> act == $past(code));

  // R6: shutdown freezes the held tap and abandons overlap
  p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && (shut || dark)) |=> (act == $past(act)) && !ovl_on);

  // R3: the overlap counter never exceeds its configured span
  p_ovl_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovl <= CW'(OVL_CYC));
endmodule

// File: rtl/tap_switch_driver.sv
module tap_switch_driver #(
  parameter int CODE_W  = 7,
  parameter int OVL_CYC = 2,
  localparam int TAPS = 1 << CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] wiper_code_i,
  input  logic              shut_req_i,
  output logic [TAPS-1:0]   tap_en_o,
  output logic              hi_end_en_o,
  output logic              wiper_low_short_o
);
  import tsd_pkg::*;

  logic [CODE_W-1:0] act, old, main_sel;
  logic              ovl_on, primed, dark;
  logic [TAPS-1:0]   main_vec, old_vec;
  term_t             term;

  tsd_seq #(.CODE_W(CODE_W), .OVL_CYC(OVL_CYC)) u_seq (
    .clk(clk_i), .rst_n(rst_ni), .code(wiper_code_i), .shut(shut_req_i),
    .act(act), .old(old), .ovl_on(ovl_on), .primed(primed), .dark(dark)
  );

  assign main_sel = primed ? act : wiper_code_i;

  tsd_decoder #(.CODE_W(CODE_W)) u_dec_main (
    .sel(main_sel), .en(!dark), .onehot(main_vec)
  );

  tsd_decoder #(.CODE_W(CODE_W)) u_dec_old (
    .sel(old), .en(!dark && primed && ovl_on), .onehot(old_vec)
  );

  assign term              = dark ? TERM_DARK : TERM_RUN;
  assign tap_en_o          = main_vec | old_vec;
  assign hi_end_en_o       = term.hi_en;
  assign wiper_low_short_o = term.lo_short;

  // R2: exactly one tap when settled
  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dark && !ovl_on) |-> $countones(tap_en_o) == 1);

  // R3: two taps while overlapping distinct positions
  p_two_taps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dark && primed && ovl_on && (old != act)) |-> $countones(tap_en_o) == 2);

  // R5: shutdown opens all taps and the upper end, shorts the wiper low
  p_dark_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dark |-> (tap_en_o == '0) && wiper_low_short_o && !hi_end_en_o);

  // R7: consecutive vectors share a closed tap
  p_mbb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && $past(primed) && !dark && !$past(dark))
      |-> (($past(tap_en_o) & tap_en_o) != '0));
endmodule

// File: tb/test_tap_switch_driver.sv
module test_tap_switch_driver;
  localparam int CW = 7;
  localparam int NT = 1 << CW;
  localparam int OVL = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] code = '0;
  logic          shut = 1'b0;
  logic [NT-1:0] tap_en;
  logic          hi_en, lo_short;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  bit            m_primed, m_sd;
  logic [CW-1:0] m_act, m_old;
  int            m_ovl;
  logic [NT-1:0] prev_vec;
  bit            prev_ok;

  always #2 clk = ~clk;

  tap_switch_driver #(.CODE_W(CW), .OVL_CYC(OVL)) i_tap_switch_driver (
    .clk_i(clk), .rst_ni(rst_n), .wiper_code_i(code), .shut_req_i(shut),
    .tap_en_o(tap_en), .hi_end_en_o(hi_en), .wiper_low_short_o(lo_short)
  );

  function automatic logic [NT-1:0] onehot(input logic [CW-1:0] c);
    logic [NT-1:0] v = '0;
    v[c] = 1'b1;
    return v;
  endfunction

  function automatic logic [NT-1:0] exp_vec();
    if (m_sd) return '0;
    if (!m_primed) return onehot(code);
    return onehot(m_act) | ((m_ovl > 0) ? onehot(m_old) : '0);
  endfunction

  task automatic model_edge(input logic [CW-1:0] cd, input bit sh);
    if (!m_primed) begin
      m_act = cd; m_primed = 1'b1; m_ovl = 0;
    end else if (sh || m_sd) begin
      m_ovl = 0;
    end else if (cd != m_act) begin
      if (m_ovl == 0) m_old = m_act;
      m_act = cd; m_ovl = OVL;
    end else if (m_ovl > 0) begin
      m_ovl--;
    end
    m_sd = sh;
  endtask

  task automatic check(input string tag);
    logic [NT-1:0] e = exp_vec();
    checks++;
    if (tap_en !== e || hi_en !== !m_sd || lo_short !== m_sd) begin
      errors++;
      $display("FAIL %s: taps=%h hi=%b sh=%b expected taps=%h hi=%b sh=%b",
               tag, tap_en, hi_en, lo_short, e, !m_sd, m_sd);
    end
    if (!m_sd && prev_ok && m_primed) begin
      checks++;
      if ((prev_vec & tap_en) == '0) begin
        errors++;
        $display("FAIL R7: taps=%h prev=%h expected a common tap", tap_en, prev_vec);
      end
    end
    prev_vec = tap_en;
    prev_ok  = !m_sd && m_primed;
  endtask

  task automatic step(input logic [CW-1:0] cd, input bit sh, input string tag);
    code = cd; shut = sh;
    @(posedge clk);
    model_edge(cd, sh);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_7a9));
    m_primed = 0; m_sd = 0; m_ovl = 0; m_act = '0; m_old = '0; prev_ok = 0;
    code = 7'd37;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check("R1");
    @(negedge clk);
    step(7'd37, 0, "R1");
    // R3 overlap and drop; R2 low boundary
    step(7'd0, 0, "R3");
    step(7'd0, 0, "R3");
    step(7'd0, 0, "R2");
    // R8 one-edge latency to the upper boundary
    step(7'd127, 0, "R8");
    step(7'd127, 0, "R3");
    step(7'd127, 0, "R2");
    // R4 re-change during overlap restarts the span
    step(7'd5, 0, "R4");
    step(7'd9, 0, "R4");
    step(7'd9, 0, "R4");
    step(7'd9, 0, "R4");
    // R5 / R6 shutdown and return to the retained tap
    step(7'd9, 1, "R5");
    step(7'd60, 1, "R6");
    step(7'd60, 0, "R6");
    step(7'd60, 0, "R6");
    step(7'd70, 1, "R5");
    step(7'd70, 0, "R6");
    step(7'd70, 0, "R6");
    // R4 change back to the original tap mid overlap
    step(7'd60, 0, "R4");
    step(7'd60, 0, "R4");
    step(7'd60, 0, "R4");
    for (int i = 0; i < 4000; i++) begin
      logic [CW-1:0] cd = code;
      bit sh = shut;
      if ($urandom_range(0, 15) == 0) sh = !sh;
      if ($urandom_range(0, 2) == 0) cd = CW'($urandom);
      step(cd, sh, m_sd ? "R5" : (m_ovl > 0 ? "R3" : "R2"));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule